// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits beside the byte-write path of a parallel memory and watches each latched address/data write. It recognises a three-byte unlock command and a six-byte chip-erase command. A sticky protection flag records that protection has been switched on. Each complete unlock command opens a grant that covers exactly one page-load session. The write controller closes that grant when it reports that the page write is finished.

While protection is off, every byte write is forwarded as a page-buffer load. While protection is on, byte writes are forwarded only when a grant is open. A complete erase command raises a single-cycle erase request, whatever the protection state.

Command bytes use the same write strobe as ordinary data bytes. The matcher advances only on strobe cycles, so any number of idle cycles may separate the bytes of a command. Only the low address bits are compared against the command addresses.

Top module: `wp_cmd_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears protect_en, write_grant, erase_req, load_en and the matcher. The cycle after reset all four flag outputs read 0.
- R2: The unlock command is three strobes in a row: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. The cycle after the third strobe, protect_en is 1. It then stays 1 until reset.
- R3: Every complete unlock command sets write_grant in the cycle after its last strobe. write_grant is 0 in the cycle after a clock edge that samples wr_done high, unless an unlock command completes at that same edge; completion wins. write_grant is never 1 while protect_en is 0.
- R4: The erase command is six strobes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555. erase_req is 1 for exactly the one cycle after the sixth strobe.
- R5: A strobe that does not match the next expected byte of a command returns the matcher to idle. If that strobe is 0xAA@0x5555, it counts as the first byte of a new command.
- R6: Only wr_addr[14:0] is compared with the command addresses. The upper address bits do not affect matching.
- R7: While protect_en is 0, every strobe gives load_en = 1 in the next cycle. In that cycle, load_addr and load_data carry the strobe's address and data. Command bytes are included.
- R8: While protect_en is 1 and write_grant is 0, a strobe gives load_en = 0 in the next cycle.
- R9: While write_grant is 1, every strobe is forwarded as a load, as in R7.
- R10: Cycles without a strobe do not advance or reset the matcher. Idle gaps between command bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle strobe for a latched byte write |
| wr_addr | input | 17 | Latched write address |
| wr_data | input | 8 | Latched write data |
| wr_done | input | 1 | Write controller reports that the page write has finished |
| protect_en | output | 1 | Protection has been enabled |
| write_grant | output | 1 | One-page write permission is open |
| erase_req | output | 1 | One-cycle whole-array erase request |
| load_en | output | 1 | Forwarded page-buffer load, valid one cycle after the strobe |
| load_addr | output | 17 | Address of the forwarded load |
| load_data | output | 8 | Data of the forwarded load |

## Verification
The hardest states to reach are the matcher's recovery paths. One is a mismatching byte that must restart the match instead of dropping it. The other is a wr_done that arrives on the same edge as the final unlock byte. The stimulus builds both deliberately. It repeats 0xAA@0x5555 as the second byte and then finishes the command. It also opens a grant, sends the first two unlock bytes under that grant, and asserts wr_done together with the third byte. The erase path is also driven with an error at its fourth byte, to show that a partial match never raises a request.

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq #(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int CW = 15,
  parameter logic [CW-1:0] A_HI  = 15'h5555,
  parameter logic [CW-1:0] A_LO  = 15'h2AAA,
  parameter logic [DW-1:0] D_KEY1 = 8'hAA,
  parameter logic [DW-1:0] D_KEY2 = 8'h55,
  parameter logic [DW-1:0] D_WRT  = 8'hA0,
  parameter logic [DW-1:0] D_ERS  = 8'h80,
  parameter logic [DW-1:0] D_ERS2 = 8'h10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_done,
  output logic          protect_en,
  output logic          write_grant,
  output logic          erase_req,
  output logic          load_en,
  output logic [AW-1:0] load_addr,
  output logic [DW-1:0] load_data
);

  logic [2:0] st, st_n;
  wire [CW-1:0] a = wr_addr[CW-1:0];

  wire k1  = wr_stb && a == A_HI && wr_data == D_KEY1;
  wire k2  = wr_stb && a == A_LO && wr_data == D_KEY2;
  wire kw  = wr_stb && a == A_HI && wr_data == D_WRT;
  wire ke  = wr_stb && a == A_HI && wr_data == D_ERS;
  wire ke2 = wr_stb && a == A_HI && wr_data == D_ERS2;

  wire unlock_hit = st == 3'd2 && kw;
  wire erase_hit  = st == 3'd5 && ke2;
  wire restart    = k1 ? 1'b1 : 1'b0;

  always_comb begin
    st_n = st;
    if (wr_stb) begin
      case (st)
        3'd0: st_n = k1 ? 3'd1 : 3'd0;
        3'd1: st_n = k2 ? 3'd2 : {2'b00, restart};
        3'd2: st_n = ke ? 3'd3 : {2'b00, restart};
        3'd3: st_n = k1 ? 3'd4 : 3'd0;
        3'd4: st_n = k2 ? 3'd5 : {2'b00, restart};
        3'd5: st_n = ke2 ? 3'd0 : {2'b00, restart};
        default: st_n = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= 3'd0;
      protect_en  <= 1'b0;
      write_grant <= 1'b0;
      erase_req   <= 1'b0;
      load_en     <= 1'b0;
      load_addr   <= '0;
      load_data   <= '0;
    end else begin
      st        <= st_n;
      erase_req <= erase_hit;
      if (unlock_hit) protect_en <= 1'b1;
      if (unlock_hit) write_grant <= 1'b1;
      else if (wr_done) write_grant <= 1'b0;
      load_en   <= wr_stb && (!protect_en || write_grant);
      load_addr <= wr_addr;
      load_data <= wr_data;
    end
  end

  p_prot_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    protect_en |=> protect_en);

  p_grant_release_r3: assert property (@(posedge clk) disable iff (rst)
    (write_grant && wr_done && !wr_stb) |=> !write_grant);

  p_grant_needs_prot_r3: assert property (@(posedge clk) disable iff (rst)
    write_grant |-> protect_en);

  p_erase_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> !erase_req);

  p_pass_open_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !protect_en) |=> (load_en && load_data == $past(wr_data)));

  p_block_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && protect_en && !write_grant) |=> !load_en);

endmodule

// File: tb/sim_wp_cmd_seq.sv
`timescale 1ns/1ps
module sim_wp_cmd_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_done = 1'b0;
  logic protect_en, write_grant, erase_req, load_en;
  logic [16:0] load_addr;
  logic [7:0] load_data;

  always #2.5 clk = ~clk;

  wp_cmd_seq u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .protect_en(protect_en), .write_grant(write_grant),
    .erase_req(erase_req), .load_en(load_en), .load_addr(load_addr), .load_data(load_data)
  );

  typedef struct {
    int          due;
    logic        ld;
    logic [16:0] la;
    logic [7:0]  lv;
    logic        er, gr, pe;
    string       req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (load_en !== e.ld || erase_req !== e.er || write_grant !== e.gr ||
          protect_en !== e.pe ||
          (e.ld && (load_addr !== e.la || load_data !== e.lv))) begin
        bad++;
        $display("FAIL %s: got ld=%b la=%h lv=%h er=%b gr=%b pe=%b exp ld=%b la=%h lv=%h er=%b gr=%b pe=%b",
                 e.req, load_en, load_addr, load_data, erase_req, write_grant, protect_en,
                 e.ld, e.la, e.lv, e.er, e.gr, e.pe);
      end
    end
  end

  task automatic step(input logic r, input logic s, input logic [16:0] ad, input logic [7:0] dt,
                      input logic dn, input logic eld, input logic eer, input logic egr,
                      input logic epe, input string req);
    exp_t e;
    @(posedge clk);
    #1;
    rst = r; wr_stb = s; wr_addr = ad; wr_data = dt; wr_done = dn;
    e.due = cyc + 1; e.ld = eld; e.la = ad; e.lv = dt;
    e.er = eer; e.gr = egr; e.pe = epe; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input logic egr, input logic epe, input string req);
    step(0, 0, 17'h0, 8'h0, 0, 0, 0, egr, epe, req);
  endtask

  initial begin
    step(1, 0, 17'h0, 8'h0, 0, 0, 0, 0, 0, "R1 reset");
    step(1, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 0, "R1 reset with strobe");
    idle(0, 0, "R1 after reset");
    step(0, 1, 17'h00123, 8'h5A, 0, 1, 0, 0, 0, "R7 open pass");
    step(0, 1, 17'h05555, 8'hAA, 0, 1, 0, 0, 0, "R7 cmd byte passed");
    step(0, 1, 17'h02AAA, 8'h55, 0, 1, 0, 0, 0, "R7 cmd byte passed");
    step(0, 1, 17'h05555, 8'hA0, 0, 1, 0, 1, 1, "R2 R3 first unlock");
    step(0, 1, 17'h1F000, 8'h3C, 0, 1, 0, 1, 1, "R9 granted load");
    step(0, 0, 17'h0, 8'h0, 1, 0, 0, 0, 1, "R3 done clears grant");
    step(0, 1, 17'h00400, 8'h77, 0, 0, 0, 0, 1, "R8 locked stray byte");
    step(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1, "R8 locked cmd byte");
    idle(0, 1, "R10 gap");
    idle(0, 1, "R10 gap");
    step(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1, "R10 after gap");
    step(0, 1, 17'h05555, 8'hA0, 0, 0, 0, 1, 1, "R10 R3 unlock across gaps");
    step(0, 0, 17'h0, 8'h0, 1, 0, 0, 0, 1, "R3 done");
    step(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1, "R5 start");
    step(0, 1, 17'h02AAA, 8'h33, 0, 0, 0, 0, 1, "R5 mismatch");
    step(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1, "R5 out of order");
    step(0, 1, 17'h05555, 8'hA0, 0, 0, 0, 0, 1, "R5 no grant after abort");
    step(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1, "R5 start");
    step(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1, "R5 restart byte");
    step(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1, "R5 restart");
    step(0, 1, 17'h05555, 8'hA0, 0, 0, 0, 1, 1, "R5 restart grants");
    step(0, 0, 17'h0, 8'h0, 1, 0, 0, 0, 1, "R3 done");
    step(0, 1, 17'h1D555, 8'hAA, 0, 0, 0, 0, 1, "R6 high bits");
    step(0, 1, 17'h0AAAA, 8'h55, 0, 0, 0, 0, 1, "R6 high bits");
    step(0, 1, 17'h15555, 8'hA0, 0, 0, 0, 1, 1, "R6 unlock with high bits");
    step(0, 0, 17'h0, 8'h0, 1, 0, 0, 0, 1, "R3 done");
    step(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1, "R4 e1");
    step(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1, "R4 e2");
    step(0, 1, 17'h05555, 8'h80, 0, 0, 0, 0, 1, "R4 e3");
    step(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1, "R4 e4");
    step(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1, "R4 e5");
    step(0, 1, 17'h05555, 8'h10, 0, 0, 1, 0, 1, "R4 erase pulse");
    idle(0, 1, "R4 pulse ends");
    step(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1, "R5 e1");
    step(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1, "R5 e2");
    step(0, 1, 17'h05555, 8'h80, 0, 0, 0, 0, 1, "R5 e3");
    step(0, 1, 17'h05555, 8'h99, 0, 0, 0, 0, 1, "R5 e4 wrong");
    step(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1, "R5 e5");
    step(0, 1, 17'h05555, 8'h10, 0, 0, 0, 0, 1, "R5 no erase");
    step(0, 1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1, "R3 u1");
    step(0, 1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1, "R3 u2");
    step(0, 1, 17'h05555, 8'hA0, 0, 0, 0, 1, 1, "R3 grant open");
    step(0, 1, 17'h05555, 8'hAA, 0, 1, 0, 1, 1, "R9 cmd under grant");
    step(0, 1, 17'h02AAA, 8'h55, 0, 1, 0, 1, 1, "R9 cmd under grant");
    step(0, 1, 17'h05555, 8'hA0, 1, 1, 0, 1, 1, "R3 completion beats done");
    step(0, 0, 17'h0, 8'h0, 1, 0, 0, 0, 1, "R3 done");
    step(1, 0, 17'h0, 8'h0, 0, 0, 0, 0, 0, "R1 reset clears protection");
    step(0, 1, 17'h00042, 8'hC3, 0, 1, 0, 0, 0, "R1 R7 open after reset");
    idle(0, 0, "R1 idle");
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule